// File: doc/BRIEF.md
# HDLC Transparent Frame Transmitter on a Slotted Serial Line

This block turns host-supplied frames into an HDLC bit stream on a time-division serial line. The host pushes every byte of a frame through a byte stream with a valid/ready handshake and marks the final byte. Address, control and payload all arrive this way, and the block adds none of them. A one-cycle send command starts the frame. The block adds an opening flag and, unless told not to, a 16-bit frame check sequence. It inserts zeros so that no field data can look like a flag, and it ends the frame with a closing flag.

The serial line repeats a frame of bit slots: two slots for the D channel, eight for B1 and eight for B2. The slot being offered in the current cycle is shown by a strobe and a channel code. Three enable bits choose which channels carry HDLC bits, in any mix. A frame always starts in the first enabled slot of a serial frame.

Between frames the line carries either repeated flags or continuous ones. Idle ones are the fill to use where the line arbitrates access with collision resolution. A new fill choice takes effect only while no frame is in progress. If the byte stream runs dry before the final byte, the block aborts the frame with eight ones and returns to fill.

Top module: `hdlc_slot_tx`

## Requirements
- R1: While reset is held, `busy` and `in_ready` are low and `tx_bit` is 1.
- R2: After `cmd_send`, the opening flag (bits 0,1,1,1,1,1,1,0 in time order) starts in the first enabled slot of the next serial frame. A serial frame begins at the slot marked by `slot_first`. If the send command is registered before any enabled slot of the current serial frame has been used, that frame's first enabled slot counts.
- R3: A bit is taken (`tx_take`=1) exactly when `slot_valid` is 1 and the channel code (`slot_ch`: 0=D, 1=B1, 2=B2, 3=none) selects a channel whose bit in `ch_en` is set. Enable bit 0 is D, bit 1 is B1 and bit 2 is B2. In every slot that is not taken, `tx_bit` is 1.
- R4: Frame bytes are sent least significant bit first. After five consecutive ones in the byte or check-sequence fields, a 0 is inserted. This also applies just before the closing flag. Flags, abort and fill are never stuffed.
- R5: When `cfg_no_fcs` is 0 at frame start, the frame check sequence follows the last byte. It is CRC-16 with polynomial x^16+x^12+x^5+1, computed bit-reflected from a preset of 0xFFFF, and its ones complement is sent bit 0 first. When `cfg_no_fcs` is 1, the closing flag follows the last byte directly.
- R6: A closing flag follows the frame, and the block then returns to fill with `busy` low.
- R7: Fill is continuous ones when `cfg_idle_fill` is 1 and repeated flags when it is 0. Flag fill restarts on a whole flag after each frame. While idle, a change applies at once. While a frame is in progress, the selection is held, and the value present when the frame ends applies.
- R8: If the last byte of a field has been sent and no next byte is waiting (with no final marker seen), the block sends eight ones and then returns to fill.
- R9: `cmd_reset` ends any frame at once. It clears a pending send and any prefetched byte, so that fill follows and a later frame contains only its own bytes.
- R10: The block accepts at most one byte ahead of the one being sent. `in_ready` is high only during a frame, and a frame consumes exactly the bytes up to and including the one marked `in_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | A bit slot is offered this cycle |
| slot_ch | input | 2 | Channel of the slot: 0=D, 1=B1, 2=B2, 3=none |
| slot_first | input | 1 | Slot is the first of a serial frame |
| ch_en | input | 3 | Channel enables: bit 0 D, bit 1 B1, bit 2 B2 |
| cfg_no_fcs | input | 1 | Suppress the frame check sequence |
| cfg_idle_fill | input | 1 | Fill with ones (1) or flags (0) |
| cmd_send | input | 1 | Start a frame |
| cmd_reset | input | 1 | Transmitter reset command |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of the frame |
| in_valid | input | 1 | Byte available |
| in_ready | output | 1 | Byte accepted when valid is also high |
| tx_bit | output | 1 | Serial bit for the current slot |
| tx_take | output | 1 | The current slot carries an HDLC bit |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest conditions to reach from the ports are a one-run stuffing bit falling just before the closing flag and a frame start that depends on where the command lands in the serial frame. The stimulus sweeps every non-empty channel-enable mix, each with its own byte count and byte values chosen arithmetically. It includes runs of 0xFF and an all-ones frame on the single B2 channel. A bench model tracks the first enabled slot on its own and compares every taken bit with a stream it builds itself, including its own byte-wise CRC. Underrun is forced by withholding the final marker. Reset is tested mid-frame with a prefetched byte outstanding.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;
  localparam logic [7:0] FLAG_PAT = 8'h7E;
  localparam logic [15:0] FCS_POLY_REFL = 16'h8408;
  localparam logic [15:0] FCS_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_FILL, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
  } tx_state_e;

  // one bit of the reflected CRC-16 update
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? FCS_POLY_REFL : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_slot_gate.sv
`timescale 1ns/1ps
module hdlc_slot_gate #(
  parameter int N_CH = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_valid,
  input  logic [SEL_W-1:0] slot_ch,
  input  logic             slot_first,
  input  logic [N_CH-1:0]  ch_en,
  output logic             take,
  output logic             first_en
);
  logic [N_CH-1:0] hit;
  logic            seen_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign hit[g] = slot_valid && (slot_ch == SEL_W'(g)) && ch_en[g];
  end

  assign take     = |hit;
  assign first_en = take && (slot_first || !seen_q);

  always_ff @(posedge clk) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (slot_first) seen_q <= take;
    else if (take)       seen_q <= 1'b1;
  end

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    first_en |=> (!first_en || slot_first)); // R2
  AST_TAKE_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> slot_valid); // R3
endmodule

// File: rtl/hdlc_fcs.sv
`timescale 1ns/1ps
module hdlc_fcs
  import hdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc_nx
);
  logic [15:0] crc_q;

  assign crc_nx = fcs_step(crc_q, din);

  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= FCS_PRESET;
    else if (clr) crc_q <= FCS_PRESET;
    else if (en)  crc_q <= crc_nx;
  end

  AST_FCS_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == FCS_PRESET)); // R5
endmodule

// File: rtl/hdlc_tx_framer.sv
`timescale 1ns/1ps
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FCS_W = 16,
  parameter int ABORT_LEN = 8,
  parameter int RUN_MAX = 5,
  localparam int CNT_W = $clog2(FCS_W),
  localparam int ONES_W = $clog2(RUN_MAX + 1),
  localparam int FILL_W = $clog2(8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first_en,
  input  logic              cfg_no_fcs,
  input  logic              cfg_idle_fill,
  input  logic              cmd_send,
  input  logic              cmd_reset,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FCS_W-1:0]  crc_nx,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              crc_bit,
  output logic              bit_out,
  output logic              busy
);
  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic [FCS_W-1:0]  sh_q, sh_d;
  logic [FILL_W-1:0] fidx_q, fidx_d;
  logic [DATA_W-1:0] nxt_q, nxt_d;
  logic pend_q, pend_d, nocrc_q, nocrc_d, cur_last_q, cur_last_d;
  logic nxt_v_q, nxt_v_d, nxt_last_q, nxt_last_d, got_last_q, got_last_d;
  logic fill_sel_q, fill_sel_d;

  // named internal events
  logic start_now, stuff_now, field_bit, byte_end, in_fire;

  assign start_now = take && first_en && pend_q && (state_q == ST_FILL);
  assign stuff_now = (ones_q == ONES_W'(RUN_MAX)) &&
                     ((state_q == ST_DATA) || (state_q == ST_FCS) ||
                      ((state_q == ST_CLOSE) && (cnt_q == '0)));
  assign field_bit = take && !stuff_now &&
                     ((state_q == ST_DATA) || (state_q == ST_FCS));
  assign byte_end  = field_bit && (state_q == ST_DATA) &&
                     (cnt_q == CNT_W'(DATA_W - 1));
  assign in_ready  = ((state_q == ST_OPEN) || (state_q == ST_DATA)) &&
                     !nxt_v_q && !got_last_q;
  assign in_fire   = in_valid && in_ready;
  assign busy      = (state_q != ST_FILL);

  assign crc_clr = start_now;
  assign crc_en  = field_bit && (state_q == ST_DATA);
  assign crc_bit = sh_q[0];

  always_comb begin
    unique case (state_q)
      ST_FILL:  bit_out = start_now ? FLAG_PAT[0] :
                          (fill_sel_q ? 1'b1 : FLAG_PAT[fidx_q]);
      ST_OPEN:  bit_out = FLAG_PAT[cnt_q[FILL_W-1:0]];
      ST_DATA,
      ST_FCS:   bit_out = stuff_now ? 1'b0 : sh_q[0];
      ST_CLOSE: bit_out = stuff_now ? 1'b0 : FLAG_PAT[cnt_q[FILL_W-1:0]];
      default:  bit_out = 1'b1;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ones_d     = ones_q;
    sh_d       = sh_q;
    fidx_d     = fidx_q;
    pend_d     = pend_q | cmd_send;
    nocrc_d    = nocrc_q;
    cur_last_d = cur_last_q;
    nxt_d      = nxt_q;
    nxt_v_d    = nxt_v_q;
    nxt_last_d = nxt_last_q;
    got_last_d = got_last_q;
    if (in_fire) begin
      nxt_d      = in_data;
      nxt_v_d    = 1'b1;
      nxt_last_d = in_last;
      got_last_d = got_last_q | in_last;
    end
    if (take) begin
      unique case (state_q)
        ST_FILL: begin
          if (start_now) begin
            state_d    = ST_OPEN;
            cnt_d      = CNT_W'(1);
            pend_d     = 1'b0;
            nocrc_d    = cfg_no_fcs;
            ones_d     = '0;
            got_last_d = 1'b0;
          end else begin
            fidx_d = fidx_q + 1'b1;
          end
        end
        ST_OPEN: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(7)) begin
            cnt_d = '0;
            if (nxt_v_q) begin
              state_d    = ST_DATA;
              sh_d       = FCS_W'(nxt_q);
              cur_last_d = nxt_last_q;
              nxt_v_d    = 1'b0;
            end else begin
              state_d = ST_ABORT;
            end
          end
        end
        ST_DATA, ST_FCS: begin
          if (stuff_now) begin
            ones_d = '0;
          end else begin
            ones_d = sh_q[0] ? ones_q + 1'b1 : '0;
            sh_d   = sh_q >> 1;
            cnt_d  = cnt_q + 1'b1;
            if (byte_end) begin
              cnt_d = '0;
              if (cur_last_q) begin
                state_d = nocrc_q ? ST_CLOSE : ST_FCS;
                sh_d    = ~crc_nx;
              end else if (nxt_v_q) begin
                sh_d       = FCS_W'(nxt_q);
                cur_last_d = nxt_last_q;
                nxt_v_d    = 1'b0;
              end else begin
                state_d = ST_ABORT;
              end
            end else if ((state_q == ST_FCS) && (cnt_q == CNT_W'(FCS_W - 1))) begin
              state_d = ST_CLOSE;
              cnt_d   = '0;
            end
          end
        end
        ST_CLOSE: begin
          if (stuff_now) begin
            ones_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(7)) begin
              state_d = ST_FILL;
              cnt_d   = '0;
              fidx_d  = '0;
            end
          end
        end
        default: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ABORT_LEN - 1)) begin
            state_d = ST_FILL;
            cnt_d   = '0;
            fidx_d  = '0;
          end
        end
      endcase
    end
    if (cmd_reset) begin
      state_d    = ST_FILL;
      cnt_d      = '0;
      ones_d     = '0;
      fidx_d     = '0;
      pend_d     = 1'b0;
      nxt_v_d    = 1'b0;
      got_last_d = 1'b0;
    end
    fill_sel_d = (state_d == ST_FILL) ? cfg_idle_fill : fill_sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_FILL;
      cnt_q      <= '0;
      ones_q     <= '0;
      sh_q       <= '0;
      fidx_q     <= '0;
      pend_q     <= 1'b0;
      nocrc_q    <= 1'b0;
      cur_last_q <= 1'b0;
      nxt_q      <= '0;
      nxt_v_q    <= 1'b0;
      nxt_last_q <= 1'b0;
      got_last_q <= 1'b0;
      fill_sel_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      ones_q     <= ones_d;
      sh_q       <= sh_d;
      fidx_q     <= fidx_d;
      pend_q     <= pend_d;
      nocrc_q    <= nocrc_d;
      cur_last_q <= cur_last_d;
      nxt_q      <= nxt_d;
      nxt_v_q    <= nxt_v_d;
      nxt_last_q <= nxt_last_d;
      got_last_q <= got_last_d;
      fill_sel_q <= fill_sel_d;
    end
  end

  AST_ONES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_W'(RUN_MAX)); // R4
  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(first_en)); // R2
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fill_sel_q)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!busy && !in_ready)); // R9
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy); // R10
  AST_ONE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> !in_ready); // R10
  AST_ABORT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT) |-> (cnt_q < CNT_W'(ABORT_LEN))); // R8
endmodule

// File: rtl/hdlc_slot_tx.sv
`timescale 1ns/1ps
module hdlc_slot_tx #(
  parameter int DATA_W = 8,
  parameter int N_CH = 3,
  parameter int SEL_W = 2,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_valid,
  input  logic [SEL_W-1:0]  slot_ch,
  input  logic              slot_first,
  input  logic [N_CH-1:0]   ch_en,
  input  logic              cfg_no_fcs,
  input  logic              cfg_idle_fill,
  input  logic              cmd_send,
  input  logic              cmd_reset,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx_bit,
  output logic              tx_take,
  output logic              busy
);
  localparam int FCS_W = 16;

  logic             take_w, first_w, crc_clr, crc_en, crc_bit, bit_w;
  logic [FCS_W-1:0] crc_nx;

  hdlc_slot_gate #(.N_CH(N_CH), .SEL_W(SEL_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ch(slot_ch),
    .slot_first(slot_first), .ch_en(ch_en), .take(take_w), .first_en(first_w)
  );

  hdlc_fcs u_fcs (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(crc_bit),
    .crc_nx(crc_nx)
  );

  hdlc_tx_framer #(.DATA_W(DATA_W), .FCS_W(FCS_W), .ABORT_LEN(ABORT_LEN)) u_framer (
    .clk(clk), .rst_n(rst_n), .take(take_w), .first_en(first_w),
    .cfg_no_fcs(cfg_no_fcs), .cfg_idle_fill(cfg_idle_fill),
    .cmd_send(cmd_send), .cmd_reset(cmd_reset),
    .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .crc_nx(crc_nx), .crc_clr(crc_clr), .crc_en(crc_en), .crc_bit(crc_bit),
    .bit_out(bit_w), .busy(busy)
  );

  assign tx_take = take_w;
  assign tx_bit  = take_w ? bit_w : 1'b1;

  AST_LINE_IDLE_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_valid) |-> tx_bit); // R3
endmodule

// File: tb/sim_hdlc_slot_tx.sv
`timescale 1ns/1ps
module sim_hdlc_slot_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_valid = 1'b0, slot_first = 1'b0;
  logic [1:0] slot_ch = 2'd3;
  logic [2:0] ch_en = 3'b000;
  logic cfg_no_fcs = 1'b0, cfg_idle_fill = 1'b1, cmd_send = 1'b0, cmd_reset = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_last = 1'b0, in_valid = 1'b0;
  logic in_ready, tx_bit, tx_take, busy;

  hdlc_slot_tx u0 (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ch(slot_ch),
    .slot_first(slot_first), .ch_en(ch_en), .cfg_no_fcs(cfg_no_fcs),
    .cfg_idle_fill(cfg_idle_fill), .cmd_send(cmd_send), .cmd_reset(cmd_reset),
    .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .tx_bit(tx_bit), .tx_take(tx_take), .busy(busy)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, take_err = 0;
  logic [7:0] fbytes [0:15];
  int fn = 0, fidx = 0;
  bit f_on = 0, f_last = 0;
  bit seen_m = 0, pend_m = 0, started = 0, cap_on = 0, send_req = 0, rst_req = 0;
  logic cap [0:1023];
  logic expb [0:1023];
  int cap_n = 0, exp_n = 0, ones_e = 0;

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    int pos;
    bit tk;
    @(negedge clk);
    pos = cyc % 19;
    slot_valid = (pos != 18);
    slot_first = (pos == 0);
    slot_ch    = (pos < 2) ? 2'd0 : (pos < 10) ? 2'd1 : (pos < 18) ? 2'd2 : 2'd3;
    in_valid   = f_on && (fidx < fn);
    in_data    = fbytes[fidx % 16];
    in_last    = f_last && (fidx == fn - 1);
    cmd_send   = send_req; send_req = 0;
    cmd_reset  = rst_req;  rst_req = 0;
    #1;
    tk = slot_valid && (slot_ch != 2'd3) && ch_en[slot_ch];
    if (tx_take !== tk) take_err++;
    if (tk && !started && pend_m && (slot_first || !seen_m) && !cmd_reset) begin
      started = 1; pend_m = 0;
    end
    if (slot_first) seen_m = tk; else if (tk) seen_m = 1;
    if (cap_on && started && tk && cap_n < 1024) begin cap[cap_n] = tx_bit; cap_n++; end
    if (in_valid && in_ready) fidx++;
    if (cmd_send) pend_m = 1;
    if (cmd_reset) pend_m = 0;
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  endtask

  task automatic push(logic b);
    expb[exp_n] = b; exp_n++;
  endtask

  task automatic push_flag();
    for (int j = 0; j < 8; j++) push(8'h7E >> j);
  endtask

  task automatic push_field(logic b);
    if (ones_e == 5) begin push(1'b0); ones_e = 0; end
    push(b);
    ones_e = b ? ones_e + 1 : 0;
  endtask

  // expected line bits: flag, stuffed bytes (+fcs), flag, 8 fill bits
  task automatic build_exp(int n, bit with_fcs, bit flag_fill_after);
    logic [15:0] c;
    exp_n = 0; ones_e = 0; c = 16'hFFFF;
    push_flag();
    for (int k = 0; k < n; k++) begin
      c = c ^ {8'h00, fbytes[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      for (int j = 0; j < 8; j++) push_field(fbytes[k][j]);
    end
    if (with_fcs) begin
      c = ~c;
      for (int j = 0; j < 16; j++) push_field(c[j]);
    end
    if (ones_e == 5) push(1'b0);
    push_flag();
    if (flag_fill_after) push_flag(); else for (int j = 0; j < 8; j++) push(1'b1);
  endtask

  task automatic build_abort(int n);
    exp_n = 0; ones_e = 0;
    push_flag();
    for (int k = 0; k < n; k++) for (int j = 0; j < 8; j++) push_field(fbytes[k][j]);
    for (int j = 0; j < 8; j++) push(1'b1);
    push_flag();
  endtask

  task automatic compare(string req, string what);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < exp_n; i++)
      if (i >= cap_n || cap[i] !== expb[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, req, what, first, -1);
  endtask

  // run one frame; flip_fill toggles the fill choice mid-frame
  task automatic run_frame(int n, bit last, bit nocrc, bit idle_fill, bit flip_fill, string req);
    int guard;
    cfg_no_fcs = nocrc; cfg_idle_fill = idle_fill;
    step(); step();
    fidx = 0; fn = n; f_on = 1; f_last = last;
    started = 0; cap_n = 0; cap_on = 1; send_req = 1;
    guard = 0;
    while (cap_n < exp_n && guard < 6000) begin
      step(); guard++;
      if (flip_fill && cap_n == 12) cfg_idle_fill = !idle_fill;
    end
    f_on = 0; cap_on = 0;
    compare(req, "frame bit stream");
    check(fidx == n, "R10", "bytes consumed", fidx, n);
    check(busy == 1'b0, "R6", "busy after frame", busy, 0);
  endtask

  initial begin
    int cnt;
    bit ok;
    repeat (3) step();
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    check(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    rst_n = 1'b1;

    // R3: no channel enabled, nothing taken
    ch_en = 3'b000; cnt = 0;
    for (int i = 0; i < 40; i++) begin step(); if (tx_take) cnt++; end
    check(cnt == 0, "R3", "takes with no channel enabled", cnt, 0);

    // R2 R4 R5 R6: sweep every channel mix
    for (int i = 1; i < 8; i++) begin
      ch_en = 3'(i);
      for (int k = 0; k < i; k++) fbytes[k] = 8'((i * 29 + k * 53 + 7) & 255);
      if (i > 1) fbytes[1] = 8'hFF;
      build_exp(i, !(i == 3 || i == 6), i[0] == 1'b0);
      run_frame(i, 1, (i == 3 || i == 6), i[0], 0, "R2/R4/R5 sweep");
    end

    // R4: all-ones frame on B2 only, stuffing into fcs and before flag
    ch_en = 3'b100;
    for (int k = 0; k < 4; k++) fbytes[k] = 8'hFF;
    build_exp(4, 1, 0);
    run_frame(4, 1, 0, 1, 0, "R4 all-ones");
    build_exp(4, 0, 0);
    run_frame(4, 1, 1, 1, 0, "R5 no-fcs all-ones");

    // R7: fill choice flipped mid-frame applies after the frame
    ch_en = 3'b110;
    for (int k = 0; k < 3; k++) fbytes[k] = 8'(k * 17 + 3);
    build_exp(3, 1, 1);
    run_frame(3, 1, 0, 1, 1, "R7 held fill");

    // R7: while idle, a change applies at once
    cfg_idle_fill = 1'b1; repeat (4) step();
    started = 1; cap_on = 1; cap_n = 0;
    while (cap_n < 16) step();
    cnt = 0; for (int i = 0; i < 16; i++) if (cap[i]) cnt++;
    check(cnt == 16, "R7", "ones in idle fill", cnt, 16);
    cfg_idle_fill = 1'b0; repeat (4) step();
    cap_n = 0;
    while (cap_n < 16) step();
    cnt = 0; for (int i = 0; i < 16; i++) if (cap[i]) cnt++;
    check(cnt == 12, "R7", "ones in 16 bits of flag fill", cnt, 12);
    cap_on = 0; started = 0;

    // R8: underrun aborts
    ch_en = 3'b010;
    fbytes[0] = 8'h12; fbytes[1] = 8'h34;
    build_abort(2);
    run_frame(2, 0, 0, 0, 0, "R8 underrun");

    // R9: reset mid-frame
    ch_en = 3'b111; cfg_idle_fill = 1'b1; cfg_no_fcs = 1'b0;
    for (int k = 0; k < 6; k++) fbytes[k] = 8'h55;
    fidx = 0; fn = 6; f_on = 1; f_last = 1;
    started = 0; cap_n = 0; cap_on = 1; send_req = 1;
    cnt = 0;
    while (cap_n < 20 && cnt < 2000) begin step(); cnt++; end
    rst_req = 1; f_on = 0;
    step(); step();
    check(busy == 1'b0, "R9", "busy after reset command", busy, 0);
    check(in_ready == 1'b0, "R9", "in_ready after reset command", in_ready, 0);
    cap_n = 0;
    while (cap_n < 16) step();
    ok = 1; for (int i = 0; i < 16; i++) if (cap[i] !== 1'b1) ok = 0;
    check(ok, "R9", "fill after reset command", ok, 1);
    cap_on = 0; started = 0;
    fbytes[0] = 8'hC3; fbytes[1] = 8'h0F;
    build_exp(2, 1, 0);
    run_frame(2, 1, 0, 1, 0, "R9 frame after reset");

    check(take_err == 0, "R3", "tx_take mismatches", take_err, 0);
    finish_up();
  end
endmodule